// File: doc/BRIEF.md
# Dual-Clock FIFO with Gray Pointer Crossing

This block moves data words from a producer running on one clock to a consumer running on an unrelated clock. Each side keeps its own binary position counter. Each counter drives a registered Gray copy, and only that copy crosses into the other domain, through a chain of synchronizing flip-flops. Because a position moves by at most one step per clock, only one bit of the crossing value changes at a time. A late sample therefore sees either the old position or the new one, never a mixture.

The full and empty comparisons are made in their own domains and registered. Each result then passes through one further register before it reaches a port. This extra stage keeps a slow-settling synchronizer from reaching downstream logic through the comparator.

The flag ports trail the internal decision by one clock. A producer that writes in consecutive cycles may therefore see the full flag low in the cycle where the storage has already filled, and that write is dropped. Producers and consumers that leave one idle cycle after each transfer always see current flags.

The storage is a plain register array written on the write clock and read into a registered output on the read clock. Both sides use synchronous active-high resets.

Top module: `gray_afifo`

## Requirements
- R1: While and after reset, `wr_full` is 0, `rd_empty` is 1 and `rd_data` is 0.
- R2: Words leave through `rd_data` in the order they were accepted on `wr_data`, unchanged. The defaults are 16 entries of 8 bits.
- R3: With no reads, `wr_full` stays 0 through DEPTH-1 accepted writes and becomes 1 after the DEPTH-th.
- R4: A write presented while the storage is full is discarded. It neither overwrites a stored word nor changes the count.
- R5: A read presented while the storage is empty is discarded. It does not change `rd_data` and does not move the read position.
- R6: `rd_data` takes the next word at the read-clock edge that accepts a read. Otherwise it holds its value.
- R7: After a write into an empty FIFO, `rd_empty` falls within a bounded number of read clocks (synchronizer, comparator and flag stages).
- R8: After a read from a full FIFO, `wr_full` falls within a bounded number of write clocks.
- R9: The flag ports lag the transfer that sets them by two edges of their own clock. After the write that fills the storage, `wr_full` is still 0 after the first edge and 1 after the second. After the read that takes the last word, `rd_empty` behaves the same way on the read clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | Storage full, registered and resynchronized |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Registered output word |
| rd_empty | output | 1 | Storage empty, registered and resynchronized |

## Verification
A directed fill of exactly DEPTH words, then a drain, separates an off-by-one in the full comparison from a correct one. The same fill and drain pins the two-edge flag lag. Pulsing write against a full store and read against an empty store shows whether the guards leak. Such a leak appears as a marker word or a skipped word in the drained stream. Random traffic then runs under unequal clocks, first write-heavy and then read-heavy, so that both flags toggle many times while every word is compared against a bench queue.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
  parameter int unsigned DEF_DATA_W = 8;
  parameter int unsigned DEF_DEPTH  = 16;
  parameter int unsigned DEF_SYNC   = 2;
endpackage

// File: rtl/afifo_sync.sv
module afifo_sync #(
  parameter int unsigned W      = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/afifo_wr_side.sv
module afifo_wr_side #(
  parameter int unsigned AW = 4,
  localparam int unsigned PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [PW-1:0] rgray_sync,
  output logic          accept,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray,
  output logic          full
);
  localparam logic [PW-1:0] TOP2 = {2'b11, {(PW-2){1'b0}}};

  logic [PW-1:0] wbin, wbin_nxt, wgray_nxt;
  logic          full_raw, full_cmp;

  assign accept    = wr_en & ~full_raw;
  assign wbin_nxt  = wbin + PW'(accept);
  assign wgray_nxt = wbin_nxt ^ (wbin_nxt >> 1);
  assign full_cmp  = (wgray_nxt == (rgray_sync ^ TOP2));
  assign waddr     = wbin[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin     <= '0;
      wgray    <= '0;
      full_raw <= 1'b0;
      full     <= 1'b0;
    end else begin
      wbin     <= wbin_nxt;
      wgray    <= wgray_nxt;
      full_raw <= full_cmp;
      full     <= full_raw;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full_raw) |=> (wbin == $past(wbin))); // R4
  AST_WGRAY_STEP: assert property (@(posedge clk) disable iff (rst)
    $countones(wgray ^ $past(wgray)) <= 1); // R2
  AST_FULL_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !full); // R1
endmodule

// File: rtl/afifo_rd_side.sv
module afifo_rd_side #(
  parameter int unsigned AW = 4,
  localparam int unsigned PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [PW-1:0] wgray_sync,
  output logic          accept,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output logic          empty
);
  logic [PW-1:0] rbin, rbin_nxt, rgray_nxt;
  logic          empty_raw, empty_cmp;

  assign accept    = rd_en & ~empty_raw;
  assign rbin_nxt  = rbin + PW'(accept);
  assign rgray_nxt = rbin_nxt ^ (rbin_nxt >> 1);
  assign empty_cmp = (rgray_nxt == wgray_sync);
  assign raddr     = rbin[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin      <= '0;
      rgray     <= '0;
      empty_raw <= 1'b1;
      empty     <= 1'b1;
    end else begin
      rbin      <= rbin_nxt;
      rgray     <= rgray_nxt;
      empty_raw <= empty_cmp;
      empty     <= empty_raw;
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty_raw) |=> (rbin == $past(rbin))); // R5
  AST_RGRAY_STEP: assert property (@(posedge clk) disable iff (rst)
    $countones(rgray ^ $past(rgray)) <= 1); // R2
  AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> empty); // R1
endmodule

// File: rtl/afifo_mem.sv
module afifo_mem #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 4,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (rrst)    rdata <= '0;
    else if (re) rdata <= store[raddr];
  end

  AST_RDATA_HOLD: assert property (@(posedge rclk) disable iff (rrst)
    !$past(re) |-> $stable(rdata)); // R6
endmodule

// File: rtl/gray_afifo.sv
module gray_afifo #(
  parameter int unsigned DATA_W      = afifo_pkg::DEF_DATA_W,
  parameter int unsigned DEPTH       = afifo_pkg::DEF_DEPTH,
  parameter int unsigned SYNC_STAGES = afifo_pkg::DEF_SYNC
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  logic          w_acc, r_acc;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wgray_in_rd, rgray_in_wr;

  afifo_wr_side #(.AW(AW)) u_wr (
    .clk(wr_clk), .rst(wr_rst), .wr_en(wr_en), .rgray_sync(rgray_in_wr),
    .accept(w_acc), .waddr(waddr), .wgray(wgray), .full(wr_full)
  );

  afifo_rd_side #(.AW(AW)) u_rd (
    .clk(rd_clk), .rst(rd_rst), .rd_en(rd_en), .wgray_sync(wgray_in_rd),
    .accept(r_acc), .raddr(raddr), .rgray(rgray), .empty(rd_empty)
  );

  afifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
    .clk(rd_clk), .rst(rd_rst), .d(wgray), .q(wgray_in_rd)
  );

  afifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
    .clk(wr_clk), .rst(wr_rst), .d(rgray), .q(rgray_in_wr)
  );

  afifo_mem #(.DW(DATA_W), .AW(AW)) u_mem (
    .wclk(wr_clk), .we(w_acc), .waddr(waddr), .wdata(wr_data),
    .rclk(rd_clk), .rrst(rd_rst), .re(r_acc), .raddr(raddr), .rdata(rd_data)
  );

  initial begin
    if (DEPTH < 4 || (1 << AW) != DEPTH) $error("DEPTH must be a power of two, at least 4");
    if (SYNC_STAGES < 2) $error("SYNC_STAGES must be at least 2");
  end
endmodule

// File: tb/gray_afifo_test.sv
module gray_afifo_test;
  localparam int DW = 8;
  localparam int DEPTH = 16;

  logic          wr_clk = 0, rd_clk = 0;
  logic          wr_rst = 1, rd_rst = 1;
  logic          wr_en = 0, rd_en = 0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_full, rd_empty;
  logic [DW-1:0] rd_data;

  int checks = 0, errors = 0;
  logic [DW-1:0] model_q[$];
  bit writer_done;

  always #5 wr_clk = ~wr_clk;
  always #7 rd_clk = ~rd_clk;

  gray_afifo #(.DATA_W(DW), .DEPTH(DEPTH), .SYNC_STAGES(2)) uut (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty)
  );

  function automatic logic [DW-1:0] pat(input int i);
    return DW'(i * 29 + 3);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one write pulse on a single write edge; returns at the negedge after that edge
  task automatic wpulse(input logic [DW-1:0] d);
    @(negedge wr_clk); wr_en = 1; wr_data = d;
    @(negedge wr_clk); wr_en = 0;
  endtask

  task automatic rpulse();
    @(negedge rd_clk); rd_en = 1;
    @(negedge rd_clk); rd_en = 0;
  endtask

  initial begin
    repeat (150000) @(posedge wr_clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] held;
    bit seen;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge rd_clk);
    check(wr_full == 0, "R1", 32'(wr_full), 0);
    check(rd_empty == 1, "R1", 32'(rd_empty), 1);
    wr_rst = 0; rd_rst = 0;
    repeat (3) @(negedge rd_clk);
    check(wr_full == 0 && rd_empty == 1, "R1", {wr_full, rd_empty}, 32'b01);
    check(rd_data == 0, "R1", 32'(rd_data), 0);

    // fill: DEPTH-1 paced writes
    for (int i = 0; i < DEPTH - 1; i++) begin
      wpulse(pat(i));
      @(negedge wr_clk);
    end
    repeat (2) @(negedge wr_clk);
    check(wr_full == 0, "R3 before last", 32'(wr_full), 0);
    wpulse(pat(DEPTH - 1));
    check(wr_full == 0, "R9 full one edge", 32'(wr_full), 0);
    @(negedge wr_clk);
    check(wr_full == 1, "R9 full two edges", 32'(wr_full), 1);
    check(wr_full == 1, "R3 at depth", 32'(wr_full), 1);

    // writes against a full store
    for (int i = 0; i < 3; i++) wpulse(8'hEE);
    @(negedge wr_clk);
    check(wr_full == 1, "R4 still full", 32'(wr_full), 1);

    // first read, then full must clear
    repeat (6) @(negedge rd_clk);
    rpulse();
    check(rd_data == pat(0), "R2 first word", 32'(rd_data), 32'(pat(0)));
    repeat (8) @(negedge wr_clk);
    check(wr_full == 0, "R8 full clears", 32'(wr_full), 0);

    // drain the rest; marker 0xEE must never appear
    for (int i = 1; i < DEPTH; i++) begin
      @(negedge rd_clk);
      rpulse();
      if (i == DEPTH - 1) begin
        check(rd_empty == 0, "R9 empty one edge", 32'(rd_empty), 0);
        check(rd_data == pat(i), "R4 drained word", 32'(rd_data), 32'(pat(i)));
        @(negedge rd_clk);
        check(rd_empty == 1, "R9 empty two edges", 32'(rd_empty), 1);
      end else begin
        check(rd_data == pat(i), "R4 drained word", 32'(rd_data), 32'(pat(i)));
      end
    end

    // R6: rd_data holds without reads
    held = rd_data;
    repeat (5) @(negedge rd_clk);
    check(rd_data == held, "R6 hold", 32'(rd_data), 32'(held));

    // R5: reads against empty
    for (int i = 0; i < 3; i++) rpulse();
    check(rd_data == held, "R5 data unchanged", 32'(rd_data), 32'(held));
    check(rd_empty == 1, "R5 still empty", 32'(rd_empty), 1);

    // R7: one write must lift empty
    wpulse(8'h5A);
    seen = 0;
    for (int i = 0; i < 12 && !seen; i++) begin
      @(negedge rd_clk);
      if (!rd_empty) seen = 1;
    end
    check(seen, "R7 empty falls", 32'(rd_empty), 0);
    rpulse();
    check(rd_data == 8'h5A, "R5 position kept", 32'(rd_data), 32'h5A);
    repeat (3) @(negedge rd_clk);
    check(rd_empty == 1, "R7 empty again", 32'(rd_empty), 1);

    // random traffic: write-heavy then read-heavy
    for (int phase = 0; phase < 2; phase++) begin
      int pw, pr;
      pw = (phase == 0) ? 85 : 30;
      pr = (phase == 0) ? 30 : 90;
      writer_done = 0;
      fork
        begin
          bit prev;
          prev = 0;
          for (int n = 0; n < 600; n++) begin
            @(negedge wr_clk);
            if (!prev && !wr_full && ($urandom % 100) < pw) begin
              wr_en = 1; wr_data = DW'($urandom);
              model_q.push_back(wr_data);
              prev = 1;
            end else begin
              wr_en = 0; prev = 0;
            end
          end
          @(negedge wr_clk); wr_en = 0;
          writer_done = 1;
        end
        begin
          bit pend;
          logic [DW-1:0] exp;
          pend = 0;
          for (int n = 0; n < 20000; n++) begin
            @(negedge rd_clk);
            if (pend) begin
              check(rd_data == exp, "R2 random order", 32'(rd_data), 32'(exp));
              pend = 0; rd_en = 0;
            end else if (!rd_empty && ($urandom % 100) < pr) begin
              rd_en = 1; exp = model_q.pop_front(); pend = 1;
            end else begin
              rd_en = 0;
              if (writer_done && model_q.size() == 0) break;
            end
          end
          rd_en = 0;
        end
      join
      check(model_q.size() == 0, "R2 all words out", model_q.size(), 0);
    end

    repeat (8) @(negedge rd_clk);
    check(rd_empty == 1, "R7 final empty", 32'(rd_empty), 1);
    check(wr_full == 0, "R8 final not full", 32'(wr_full), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule